// File: doc/BRIEF.md
# Banked Colour Palette Lookup

This block turns each 8-bit pixel code into a 24-bit RGB colour on every pixel clock. The six low bits of the code select one of 64 colours. The two high bits select one of four separate 64-entry palettes, which gives 256 table entries of 24 bits each. The output is registered and is driven to black while the blanking input is high.

A processor changes palette entries one byte at a time. It first writes a byte that names the target entry, then writes the red, green and blue bytes in that order. Only complete entries go into a small in-order pending queue. The queue drains into the table only while vertical blanking is high, so display reads are never stalled and a half-written colour is never shown. After reset an internal sweep fills the table. Palette 0 is filled with a default ramp and palettes 1 to 3 are cleared.

Top module: `banked_palette`

## Requirements
- R1: `rgb_out` is registered. The colour for the `pix_index` and `pix_blank` sampled at clock edge N appears on `rgb_out` after edge N and holds until edge N+1. `rgb_out` is zero after any edge at which `rst` is high.
- R2: If `pix_blank` is high at an edge, `rgb_out` is zero after that edge, whatever the pixel code.
- R3: Within 300 cycles after `rst` falls, the table holds its initial contents. Palette 0 entry i has red = i[5:4]×0x55, green = i[3:2]×0x55 and blue = i[1:0]×0x55. Every entry of palettes 1 to 3 is zero. Once the sweep ends it does not restart without a reset. `rgb_out` packs the channels as red in [23:16], green in [15:8] and blue in [7:0].
- R4: `pix_index[7:6]` selects the palette and `pix_index[5:0]` selects the entry, so table address = pix_index.
- R5: A byte written with `wr_en` and `wr_is_index` both high sets the target address to `wr_data[7:0]`. The next three bytes written with `wr_is_index` low are red, green and blue, and the third one completes the entry. A colour byte written when no entry sequence is open is ignored.
- R6: A completed entry does not change the displayed table while `vblank` is low. It takes effect only after `vblank` has been high long enough for the queue to drain.
- R7: Queued entries are committed in the order they were completed, one per cycle while `vblank` is high. When the same address is written twice, the later value remains.
- R8: The pending queue holds 16 complete entries. An entry completed while the queue is full is discarded.
- R9: An entry that received fewer than three colour bytes is never committed. A new index byte abandons an open sequence and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_index | input | 8 | Pixel code: palette select in [7:6], entry in [5:0] |
| pix_blank | input | 1 | Forces the output to black |
| vblank | input | 1 | Vertical blanking; allows queued entries to commit |
| wr_en | input | 1 | Processor byte write strobe |
| wr_is_index | input | 1 | Marks the byte as a target address instead of a colour |
| wr_data | input | 8 | Processor write byte |
| rgb_out | output | 24 | Registered colour, red in [23:16], blue in [7:0] |

## Verification
Each lookup is due exactly one edge after its pixel code and blank flag are sampled. The bench drives inputs on the falling edge and samples `rgb_out` on the next falling edge, after a single rising edge. A palette write has no fixed latency at the output. The bench therefore treats a write as visible only after a whole vertical-blanking window of 24 cycles, which is longer than 16 queued commits plus the two register stages between the last colour byte and the table. It also reads the affected pixels while `vblank` is low, both before and after that window. Reset contents are checked only after a 300-cycle wait, which covers the 256-entry initial sweep.

// File: rtl/banked_palette_pkg.sv
package banked_palette_pkg;
  // Position within a processor update sequence
  typedef enum logic [1:0] {
    ASM_IDLE  = 2'd0,
    ASM_RED   = 2'd1,
    ASM_GREEN = 2'd2,
    ASM_BLUE  = 2'd3
  } asm_state_t;
endpackage

// File: rtl/palette_byte_assembler.sv
module palette_byte_assembler
  import banked_palette_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CH_W  = 8,
  localparam int RGB_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_is_index,
  input  logic [CH_W-1:0]  wr_data,
  output logic             push,
  output logic [PIX_W-1:0] push_addr,
  output logic [RGB_W-1:0] push_rgb
);
  asm_state_t        st;
  logic [PIX_W-1:0]  tgt;
  logic [CH_W-1:0]   red_q;
  logic [CH_W-1:0]   grn_q;

  // The third colour byte completes the entry in the cycle it arrives
  always_comb begin
    push      = wr_en && !wr_is_index && (st == ASM_BLUE);
    push_addr = tgt;
    push_rgb  = {red_q, grn_q, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ASM_IDLE;
      tgt   <= '0;
      red_q <= '0;
      grn_q <= '0;
    end else if (wr_en) begin
      if (wr_is_index) begin
        tgt <= wr_data[PIX_W-1:0];
        st  <= ASM_RED;
      end else begin
        case (st)
          ASM_RED:   begin red_q <= wr_data; st <= ASM_GREEN; end
          ASM_GREEN: begin grn_q <= wr_data; st <= ASM_BLUE;  end
          ASM_BLUE:  st <= ASM_IDLE;
          default:   st <= ASM_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/palette_pending_fifo.sv
module palette_pending_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             do_push;
  logic             do_pop;

  always_comb begin
    do_push = push && (count != CW'(DEPTH));
    do_pop  = pop && (count != '0);
    dout    = slots[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/palette_table_ram.sv
module palette_table_ram #(
  parameter int AW = 8,
  parameter int DW = 24,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          rblank,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with synchronous clear for reset and blanking
  always_ff @(posedge clk) begin
    if (rst || rblank) rdata <= '0;
    else               rdata <= mem[raddr];
  end
endmodule

// File: rtl/banked_palette.sv
module banked_palette #(
  parameter int IDX_W      = 6,
  parameter int BANK_W     = 2,
  parameter int CH_W       = 8,
  parameter int PEND_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BANK_W+IDX_W-1:0] pix_index,
  input  logic                    pix_blank,
  input  logic                    vblank,
  input  logic                    wr_en,
  input  logic                    wr_is_index,
  input  logic [CH_W-1:0]         wr_data,
  output logic [3*CH_W-1:0]       rgb_out
);
  localparam int PIX_W   = BANK_W + IDX_W;
  localparam int RGB_W   = 3 * CH_W;
  localparam int ENTRIES = 1 << PIX_W;
  localparam int CB      = IDX_W / 3;
  localparam int CW      = $clog2(PEND_DEPTH + 1);

  // Widen each channel field of the index to CH_W by repeating its bits
  function automatic logic [RGB_W-1:0] default_colour(input logic [IDX_W-1:0] idx);
    logic [RGB_W-1:0] c;
    c = '0;
    for (int ch = 0; ch < 3; ch++) begin
      for (int b = 0; b < CH_W; b++) begin
        c[ch*CH_W + b] = idx[ch*CB + (CB - 1 - ((CH_W - 1 - b) % CB))];
      end
    end
    return c;
  endfunction

  logic             asm_push;
  logic [PIX_W-1:0] asm_addr;
  logic [RGB_W-1:0] asm_rgb;
  logic [PIX_W+RGB_W-1:0] pend_out;
  logic [CW-1:0]    pend_cnt;
  logic             pend_pop;
  logic             init_busy;
  logic [PIX_W-1:0] init_ptr;
  logic             tbl_we;
  logic [PIX_W-1:0] tbl_waddr;
  logic [RGB_W-1:0] tbl_wdata;

  palette_byte_assembler #(.PIX_W(PIX_W), .CH_W(CH_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_is_index (wr_is_index),
    .wr_data     (wr_data),
    .push        (asm_push),
    .push_addr   (asm_addr),
    .push_rgb    (asm_rgb)
  );

  palette_pending_fifo #(.WIDTH(PIX_W + RGB_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .push  (asm_push),
    .din   ({asm_addr, asm_rgb}),
    .pop   (pend_pop),
    .dout  (pend_out),
    .count (pend_cnt)
  );

  // Post-reset sweep writes every table entry once
  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_ptr  <= '0;
    end else if (init_busy) begin
      init_ptr <= init_ptr + 1'b1;
      if (init_ptr == PIX_W'(ENTRIES - 1)) init_busy <= 1'b0;
    end
  end

  always_comb begin
    if (init_busy) begin
      tbl_we    = 1'b1;
      tbl_waddr = init_ptr;
      tbl_wdata = (init_ptr[PIX_W-1 -: BANK_W] == '0) ? default_colour(init_ptr[IDX_W-1:0]) : '0;
      pend_pop  = 1'b0;
    end else begin
      tbl_we    = vblank && (pend_cnt != '0);
      tbl_waddr = pend_out[PIX_W+RGB_W-1 -: PIX_W];
      tbl_wdata = pend_out[RGB_W-1:0];
      pend_pop  = tbl_we;
    end
  end

  palette_table_ram #(.AW(PIX_W), .DW(RGB_W)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .we     (tbl_we),
    .waddr  (tbl_waddr),
    .wdata  (tbl_wdata),
    .raddr  (pix_index),
    .rblank (pix_blank),
    .rdata  (rgb_out)
  );
endmodule

// File: rtl/banked_palette_checker.sv
module banked_palette_checker #(
  parameter int RGB_W      = 24,
  parameter int PEND_DEPTH = 16,
  localparam int CW = $clog2(PEND_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_blank,
  input logic             vblank,
  input logic [RGB_W-1:0] rgb_out,
  input logic             tbl_we,
  input logic             init_busy,
  input logic [CW-1:0]    pend_cnt
);
  assert_reset_dark_R1: assert property (@(posedge clk)
    $past(rst) |-> rgb_out == '0);

  assert_blank_black_R2: assert property (@(posedge clk) disable iff (rst)
    $past(pix_blank) |-> rgb_out == '0);

  assert_sweep_once_R3: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  assert_commit_in_vblank_R6: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && !init_busy) |-> vblank);

  assert_commit_from_queue_R7: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && !init_busy) |-> pend_cnt != '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= CW'(PEND_DEPTH));
endmodule

bind banked_palette banked_palette_checker #(
  .RGB_W(3 * CH_W), .PEND_DEPTH(PEND_DEPTH)
) u_banked_palette_checker (
  .clk       (clk),
  .rst       (rst),
  .pix_blank (pix_blank),
  .vblank    (vblank),
  .rgb_out   (rgb_out),
  .tbl_we    (tbl_we),
  .init_busy (init_busy),
  .pend_cnt  (pend_cnt)
);

// File: tb/banked_palette_bench.sv
module banked_palette_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH     = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pix_index = '0;
  logic        pix_blank = 1'b0;
  logic        vblank = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_is_index = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [23:0] rgb_out;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // Bench model of the table and the pending queue
  logic [23:0] exp_tbl [256];
  logic [7:0]  q_addr [QDEPTH];
  logic [23:0] q_rgb  [QDEPTH];
  int          q_n = 0;
  int          m_pos = 0;
  logic [7:0]  m_tgt, m_r, m_g;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_palette u_banked_palette (
    .clk(clk), .rst(rst), .pix_index(pix_index), .pix_blank(pix_blank),
    .vblank(vblank), .wr_en(wr_en), .wr_is_index(wr_is_index),
    .wr_data(wr_data), .rgb_out(rgb_out)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ramp(input int i);
    logic [7:0] r, g, b;
    r = 8'((i >> 4) & 3) * 8'h55;
    g = 8'((i >> 2) & 3) * 8'h55;
    b = 8'(i & 3) * 8'h55;
    return ((i >> 6) == 0) ? {r, g, b} : 24'h0;
  endfunction

  // Drive pixel code, one rising edge, sample on the following falling edge
  task automatic read_pix(input logic [7:0] p, input bit blk, input string tag);
    logic [23:0] e;
    @(negedge clk);
    pix_index = p;
    pix_blank = blk;
    @(posedge clk);
    @(negedge clk);
    e = blk ? 24'h0 : exp_tbl[p];
    check(rgb_out === e, tag, rgb_out, e);
  endtask

  task automatic wr_byte(input bit is_idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_is_index = is_idx;
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (is_idx) begin
      m_tgt = d;
      m_pos = 1;
    end else begin
      case (m_pos)
        1: begin m_r = d; m_pos = 2; end
        2: begin m_g = d; m_pos = 3; end
        3: begin
          if (q_n < QDEPTH) begin
            q_addr[q_n] = m_tgt;
            q_rgb[q_n] = {m_r, m_g, d};
            q_n++;
          end
          m_pos = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic write_entry(input logic [7:0] a, input logic [23:0] c);
    wr_byte(1'b1, a);
    wr_byte(1'b0, c[23:16]);
    wr_byte(1'b0, c[15:8]);
    wr_byte(1'b0, c[7:0]);
  endtask

  task automatic vblank_window(input int n);
    @(negedge clk);
    vblank = 1'b1;
    repeat (n) @(posedge clk);
    #1 vblank = 1'b0;
    for (int i = 0; i < q_n; i++) exp_tbl[q_addr[i]] = q_rgb[i];
    q_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    logic [23:0] c0;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int i = 0; i < 256; i++) exp_tbl[i] = ramp(i);

    // R1: output dark while reset is held
    pix_index = 8'h3F;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rgb_out === 24'h0, "R1 reset output", rgb_out, 24'h0);
    rst = 1'b0;
    repeat (300) @(posedge clk);

    // R3 / R4: full sweep of the initial contents
    for (int i = 0; i < 256; i++) read_pix(8'(i), 1'b0, "R3 R4 initial table");

    // R1: back-to-back codes, each due one edge later
    read_pix(8'h15, 1'b0, "R1 latency first");
    read_pix(8'h2A, 1'b0, "R1 latency second");
    // R2: blanking beats a bright code
    read_pix(8'h3F, 1'b1, "R2 blank forced");
    read_pix(8'h3F, 1'b0, "R2 blank released");

    // R6: not visible before vblank, visible after
    write_entry(8'h41, 24'hA1B2C3);
    read_pix(8'h41, 1'b0, "R6 before vblank");
    vblank_window(24);
    read_pix(8'h41, 1'b0, "R6 after vblank");
    check(exp_tbl[8'h41] === 24'hA1B2C3, "R5 model entry", exp_tbl[8'h41], 24'hA1B2C3);

    // R4: same low bits in different banks stay separate
    write_entry(8'hC1, 24'h123456);
    vblank_window(24);
    read_pix(8'hC1, 1'b0, "R4 bank 3 entry");
    read_pix(8'h41, 1'b0, "R4 bank 1 untouched");
    read_pix(8'h01, 1'b0, "R4 bank 0 untouched");

    // R7: later write to same address wins
    write_entry(8'h80, 24'h111111);
    write_entry(8'h80, 24'h222222);
    vblank_window(24);
    read_pix(8'h80, 1'b0, "R7 last write wins");

    // R9: partial sequence abandoned by a new index byte
    c0 = exp_tbl[8'h90];
    wr_byte(1'b1, 8'h90);
    wr_byte(1'b0, 8'hEE);
    wr_byte(1'b0, 8'hDD);
    write_entry(8'h91, 24'h0F0F0F);
    vblank_window(24);
    read_pix(8'h90, 1'b0, "R9 partial not committed");
    check(exp_tbl[8'h90] === c0, "R9 model unchanged", exp_tbl[8'h90], c0);
    read_pix(8'h91, 1'b0, "R9 next entry committed");

    // R5: stray colour bytes with no open sequence are ignored
    wr_byte(1'b0, 8'h77);
    wr_byte(1'b0, 8'h66);
    wr_byte(1'b0, 8'h55);
    vblank_window(24);
    read_pix(8'h91, 1'b0, "R5 stray bytes ignored");
    read_pix(8'h90, 1'b0, "R5 stray bytes ignored old");

    // R8: overflow beyond 16 queued entries is dropped
    for (int k = 0; k < 20; k++) write_entry(8'(8'hA0 + k), {8'(k), 8'hC3, 8'(8'hF0 - k)});
    vblank_window(24);
    for (int k = 0; k < 20; k++) read_pix(8'(8'hA0 + k), 1'b0, "R8 queue depth");

    // Random rounds: R5 R6 R7 R8 R9 against the model
    for (int rnd = 0; rnd < 30; rnd++) begin
      int n;
      n = 1 + int'($urandom_range(19));
      for (int k = 0; k < n; k++) begin
        int kind;
        kind = int'($urandom_range(9));
        if (kind == 0) begin
          wr_byte(1'b1, 8'($urandom));
          wr_byte(1'b0, 8'($urandom));
        end else if (kind == 1) begin
          wr_byte(1'b0, 8'($urandom));
        end else begin
          write_entry(8'($urandom), 24'($urandom));
        end
      end
      for (int k = 0; k < 4; k++) read_pix(8'($urandom), 1'b0, "R6 random pre-vblank");
      vblank_window(24);
      for (int k = 0; k < 16; k++)
        read_pix(8'($urandom), ($urandom_range(3) == 0), "R5 R7 R8 R9 random");
    end

    report();
  end
endmodule